// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight interrupt request lines should go to the processor next. It takes a snapshot of the pending-request, mask and in-service registers, along with a rotation offset and a nesting configuration. It reports whether a request should be raised and, if so, which line wins. The neighbouring register, acknowledge and cascade logic own all of those inputs. This block only evaluates them and holds no interrupt state of its own.

Priority is circular. The line named by the offset ranks highest, and each following line ranks one step lower, wrapping at eight. A pending unmasked line is granted only when it ranks strictly above every line already in service. When the block acts as the master of a cascaded pair and special nesting is enabled, the in-service bit of the cascade line is left out of that comparison. This lets a further request arriving through the cascade still get through. An optional output register, chosen by parameter, cuts the combinational path at the cost of one cycle of latency.

Top module: `prio_resolver`

## Requirements
- R1: Only lines whose request bit is 1 and whose mask bit is 0 are candidates, so a masked or idle line is never reported.
- R2: Rotated rank k (k = 0..7) maps to line (offset + k) mod 8, and rank 0 is the highest. The reported line is the candidate with the lowest rank.
- R3: When no candidate exists, `irq_valid` is 0 and `irq_line` is 0.
- R4: A candidate is granted only if its rank is strictly lower than the lowest rank among the counted in-service bits. If its rank is equal or higher, `irq_valid` is 0. If no in-service bit is counted, any candidate is granted.
- R5: When `nest_mode` = 1 and `is_master` = 1, in-service bit 2 is excluded from the in-service rank search. With either of these inputs at 0, bit 2 counts like the other bits.
- R6: With `OUT_REG` = 1 (the default), the outputs reflect the inputs sampled at the previous rising clock edge. Inputs changed between edges do not alter the outputs before the next edge. With `OUT_REG` = 0, the outputs follow the inputs combinationally.
- R7: While `rst_n` is 0, the registered outputs are held at 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 8 | Pending request bits, one per line |
| mask | input | 8 | Mask bits; 1 blocks the line |
| in_service | input | 8 | Lines currently being serviced |
| rot_offset | input | 3 | Line holding the highest priority |
| nest_mode | input | 1 | Special nesting enable |
| is_master | input | 1 | 1 when this resolver is the cascade master |
| irq_valid | output | 1 | A request should be raised |
| irq_line | output | 3 | Winning line, 0 when not valid |

## Verification
With the default output register, each result appears exactly one rising edge after its inputs are applied. The bench therefore drives each vector on a falling edge and compares on the next falling edge, half a period after the capturing edge. One directed check samples just after a drive, before the edge, and confirms that the previous result is still held. The assertions compare the outputs against copies of the inputs delayed by the same single stage, so every property relates values that belong to the same cycle.

// File: rtl/prio_res_pkg.sv
`timescale 1ns/1ps
package prio_res_pkg;
  parameter int unsigned PR_LINES   = 8;
  parameter int unsigned PR_CASCADE = 2;

  // Modular sum of a rank and an offset over n lines.
  function automatic int unsigned wrap_add(input int unsigned a, input int unsigned b,
                                           input int unsigned n);
    int unsigned s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/pr_rotator.sv
`timescale 1ns/1ps
module pr_rotator #(
  parameter int unsigned N  = prio_res_pkg::PR_LINES,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] off,
  output logic [N-1:0]  rot
);
  // rot[k] is the bit of the line that holds rank k.
  for (genvar k = 0; k < N; k++) begin : g_rank
    logic [IW:0]   sum;
    logic [IW-1:0] src;
    always_comb begin
      sum = (IW+1)'(k) + {1'b0, off};
      if (sum >= (IW+1)'(N)) sum = sum - (IW+1)'(N);
    end
    assign src    = sum[IW-1:0];
    assign rot[k] = vec[src];
  end
endmodule

// File: rtl/pr_first_set.sv
`timescale 1ns/1ps
module pr_first_set #(
  parameter int unsigned N  = prio_res_pkg::PR_LINES,
  parameter int unsigned RW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [RW-1:0] rank   // N when no bit is set
);
  always_comb begin
    rank = RW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) rank = RW'(i);
    end
  end
endmodule

// File: rtl/pr_out_stage.sv
`timescale 1ns/1ps
module pr_out_stage #(
  parameter int unsigned IW      = 3,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_valid,
  input  logic [IW-1:0] d_line,
  output logic          q_valid,
  output logic [IW-1:0] q_line
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_valid <= 1'b0;
        q_line  <= '0;
      end else begin
        q_valid <= d_valid;
        q_line  <= d_line;
      end
    end
  end else begin : g_comb
    assign q_valid = d_valid;
    assign q_line  = d_line;
  end
endmodule

// File: rtl/prio_resolver.sv
`timescale 1ns/1ps
module prio_resolver #(
  parameter int unsigned N       = prio_res_pkg::PR_LINES,
  parameter int unsigned CASCADE = prio_res_pkg::PR_CASCADE,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           req,
  input  logic [N-1:0]           mask,
  input  logic [N-1:0]           in_service,
  input  logic [$clog2(N)-1:0]   rot_offset,
  input  logic                   nest_mode,
  input  logic                   is_master,
  output logic                   irq_valid,
  output logic [$clog2(N)-1:0]   irq_line
);
  localparam int unsigned IW = $clog2(N);
  localparam int unsigned RW = $clog2(N + 1);

  logic [N-1:0]  cand, drop, isr_eff;
  logic [N-1:0]  cand_rot, isr_rot;
  logic [RW-1:0] cand_rank, isr_rank;
  logic          grant;
  logic [IW-1:0] line_c;

  assign cand    = req & ~mask;
  assign drop    = (nest_mode && is_master) ? (N'(1) << CASCADE) : '0;
  assign isr_eff = in_service & ~drop;

  pr_rotator #(.N(N), .IW(IW)) u_rot_req (.vec(cand),    .off(rot_offset), .rot(cand_rot));
  pr_rotator #(.N(N), .IW(IW)) u_rot_isr (.vec(isr_eff), .off(rot_offset), .rot(isr_rot));

  pr_first_set #(.N(N), .RW(RW)) u_fs_req (.vec(cand_rot), .rank(cand_rank));
  pr_first_set #(.N(N), .RW(RW)) u_fs_isr (.vec(isr_rot),  .rank(isr_rank));

  // A missing candidate has rank N, which never beats any in-service rank.
  assign grant  = cand_rank < isr_rank;
  assign line_c = grant
                ? IW'(prio_res_pkg::wrap_add(int'(cand_rank), int'(rot_offset), N))
                : '0;

  pr_out_stage #(.IW(IW), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n),
    .d_valid(grant), .d_line(line_c),
    .q_valid(irq_valid), .q_line(irq_line)
  );
endmodule

// File: rtl/prio_res_chk.sv
`timescale 1ns/1ps
module prio_res_chk #(
  parameter int unsigned N       = 8,
  parameter int unsigned CASCADE = 2,
  parameter bit          OUT_REG = 1'b1,
  parameter int unsigned IW      = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  in_service,
  input logic [IW-1:0] rot_offset,
  input logic          nest_mode,
  input logic          is_master,
  input logic          irq_valid,
  input logic [IW-1:0] irq_line
);
  // Inputs aligned with the cycle in which their result is visible.
  logic [N-1:0]  a_req, a_mask, a_isr;
  logic [IW-1:0] a_off;
  logic          a_nest, a_master;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_req <= '0; a_mask <= '0; a_isr <= '0; a_off <= '0;
        a_nest <= 1'b0; a_master <= 1'b0;
      end else begin
        a_req <= req; a_mask <= mask; a_isr <= in_service; a_off <= rot_offset;
        a_nest <= nest_mode; a_master <= is_master;
      end
    end
  end else begin : g_now
    assign a_req = req;       assign a_mask = mask;     assign a_isr = in_service;
    assign a_off = rot_offset; assign a_nest = nest_mode; assign a_master = is_master;
  end

  logic [N-1:0] a_cand, a_isr_cnt;
  logic         a_skip;
  assign a_cand    = a_req & ~a_mask;
  assign a_skip    = a_nest && a_master;
  assign a_isr_cnt = a_skip ? (a_isr & ~(N'(1) << CASCADE)) : a_isr;

  p_masked_never_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (a_req[irq_line] && !a_mask[irq_line]));

  p_top_rank_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cand[a_off] && !a_isr_cnt[a_off]) |-> (irq_valid && irq_line == a_off));

  p_idle_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cand == '0) |-> (!irq_valid && irq_line == '0));

  p_in_service_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !(a_skip && irq_line == IW'(CASCADE))) |-> !a_isr[irq_line]);

  p_free_service_grants_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cand != '0 && a_isr_cnt == '0) |-> irq_valid);
endmodule

bind prio_resolver prio_res_chk #(.N(N), .CASCADE(CASCADE), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .mask(mask), .in_service(in_service),
  .rot_offset(rot_offset), .nest_mode(nest_mode), .is_master(is_master),
  .irq_valid(irq_valid), .irq_line(irq_line)
);

// File: tb/prio_resolver_test.sv
`timescale 1ns/1ps
module prio_resolver_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req, mask, isr;
  logic [2:0] off;
  logic       nest, master;
  logic       irq_valid;
  logic [2:0] irq_line;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  prio_resolver uut (
    .clk(clk), .rst_n(rst_n), .req(req), .mask(mask), .in_service(isr),
    .rot_offset(off), .nest_mode(nest), .is_master(master),
    .irq_valid(irq_valid), .irq_line(irq_line)
  );

  function automatic void model(input logic [7:0] r, input logic [7:0] m, input logic [7:0] s,
                                input logic [2:0] o, input logic n, input logic ms,
                                output logic v, output logic [2:0] l);
    logic [7:0] c;
    logic [7:0] se;
    int rr;
    int sr;
    c = r & ~m;
    se = s;
    if (n && ms) se[2] = 1'b0;
    rr = 8;
    sr = 8;
    for (int k = 7; k >= 0; k--) begin
      if (c[(k + int'(o)) % 8])  rr = k;
      if (se[(k + int'(o)) % 8]) sr = k;
    end
    v = rr < sr;
    l = v ? 3'((rr + int'(o)) % 8) : 3'd0;
  endfunction

  task automatic check(input string tag, input logic ev, input logic [2:0] el);
    checks++;
    if (irq_valid !== ev || irq_line !== el) begin
      errors++;
      $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
               tag, irq_valid, irq_line, ev, el);
    end
  endtask

  // Called on a falling edge; compares one edge later.
  task automatic run(input string tag, input logic [7:0] r, input logic [7:0] m,
                     input logic [7:0] s, input logic [2:0] o, input logic n, input logic ms);
    logic ev;
    logic [2:0] el;
    req = r; mask = m; isr = s; off = o; nest = n; master = ms;
    model(r, m, s, o, n, ms, ev, el);
    @(negedge clk);
    check(tag, ev, el);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req = 8'hFF; mask = 8'h00; isr = 8'h00; off = 3'd0; nest = 1'b0; master = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset holds outputs low", 1'b0, 3'd0);
    rst_n = 1'b1;
    req = 8'h00;
    @(negedge clk);

    // R2 rotation order
    run("R2 offset 0 picks line 0",  8'b1000_0001, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0);
    run("R2 offset 7 picks line 7",  8'b1000_0001, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0);
    run("R2 offset 1 wraps to 7",    8'b1000_0001, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0);
    // R1 masking
    run("R1 masked line skipped",    8'b0000_0011, 8'b0000_0001, 8'h00, 3'd0, 1'b0, 1'b0);
    // R3 nothing eligible
    run("R3 all masked",             8'hFF, 8'hFF, 8'h00, 3'd3, 1'b0, 1'b0);
    // R4 strict comparison
    run("R4 equal rank blocked",     8'b0000_1000, 8'h00, 8'b0000_1000, 3'd0, 1'b0, 1'b0);
    run("R4 higher rank granted",    8'b0000_0100, 8'h00, 8'b0000_1000, 3'd0, 1'b0, 1'b0);
    run("R4 lower rank blocked",     8'b0001_0000, 8'h00, 8'b0000_1000, 3'd0, 1'b0, 1'b0);
    // R5 cascade exclusion
    run("R5 master nested ignores bit2", 8'b0010_0000, 8'h00, 8'b0000_0100, 3'd0, 1'b1, 1'b1);
    run("R5 slave nested counts bit2",   8'b0010_0000, 8'h00, 8'b0000_0100, 3'd0, 1'b1, 1'b0);
    run("R5 master plain counts bit2",   8'b0010_0000, 8'h00, 8'b0000_0100, 3'd0, 1'b0, 1'b1);
    run("R5 cascade line regrants",      8'b0000_0100, 8'h00, 8'b0000_0100, 3'd0, 1'b1, 1'b1);

    // R6 latency: a change between edges leaves the held result
    req = 8'h00; mask = 8'h00; isr = 8'h00; off = 3'd0; nest = 1'b0; master = 1'b0;
    @(negedge clk);
    req = 8'b0100_0000;
    #1;
    check("R6 output waits for edge", 1'b0, 3'd0);
    @(negedge clk);
    check("R6 output after one edge", 1'b1, 3'd6);

    // R2/R4/R5 sweep: every offset, every request pattern, single or no in-service bit
    for (int o = 0; o < 8; o++) begin
      for (int s = 0; s < 9; s++) begin
        for (int r = 0; r < 256; r++) begin
          run("R2 sweep sparse service", 8'(r), 8'h00, (s == 8) ? 8'h00 : 8'(1 << s),
              3'(o), r[0], r[1]);
        end
      end
    end
    // R1/R4/R5 sweep with random mask and service patterns
    for (int o = 0; o < 8; o++) begin
      for (int r = 0; r < 256; r++) begin
        for (int j = 0; j < 4; j++) begin
          run("R1 sweep random mask", 8'(r), 8'($urandom & $urandom),
              8'($urandom & $urandom & $urandom), 3'(o), j[0], j[1]);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule